// File: doc/BRIEF.md
# Second-Operand Barrel Shifter with Carry Rotation

This block reshapes the second source operand of an arithmetic unit before it reaches the adder or the logic unit. It accepts a data word, a shift kind, a five-bit distance and the current carry flag. It returns the shifted word and a carry-out that the flag logic can use. The shift kinds are logical left, logical right, arithmetic right, rotate right and a one-place rotate right through the carry flag.

The datapath is a chain of five multiplexer stages. Each stage moves the word by a power-of-two distance. A left shift reuses the same right-moving chain by reversing the bit order on the way in and again on the way out. The carry-out is chosen from the original operand by a separate index path that runs in parallel with the chain. The result and the carry-out are captured in an output register, so every accepted request yields one result one cycle later.

Top module: `opshift_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `out_valid`, `result` and `carry_out` are all zero.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. When `in_valid` is low, `result` and `carry_out` hold their previous values.
- R3: Kind code 0 (logical left) by n in 1..31 moves the bits up by n and fills the low bits with zeros. The carry-out is operand bit 32-n.
- R4: Kind code 1 (logical right) by n in 1..31 moves the bits down by n and fills the high bits with zeros. The carry-out is operand bit n-1.
- R5: Kind code 2 (arithmetic right) by n in 1..31 fills the high bits with copies of operand bit 31. The carry-out is operand bit n-1.
- R6: Kind code 3 (rotate right) by n in 1..31 moves the bits that leave bit 0 into bit 31, so the number of set bits is unchanged. The carry-out is operand bit n-1, which equals the new bit 31.
- R7: Kind code 4 (extended rotate) gives {carry_in, operand[31:1]} with carry-out operand[0], whatever the value of `amount`.
- R8: For kind codes 0 to 3 with `amount` 0, `result` equals the operand and `carry_out` equals `carry_in`.
- R9: Kind codes 5, 6 and 7 are reserved and behave as a pass-through: the operand and `carry_in` appear unchanged at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| operand | input | 32 | Word to be shifted |
| kind | input | 3 | Shift kind code (0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 extended rotate) |
| amount | input | 5 | Shift distance |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result registered from the previous request |
| result | output | 32 | Shifted word |
| carry_out | output | 1 | Carry produced by the shift |

## Verification
Two rules can apply to the same request: the zero-distance pass-through and the extended rotate. An extended rotate sent with `amount` 0 and another sent with a nonzero `amount` must both produce the rotated word, never the pass-through. In each case the carry-out must be the old bit 0 and not `carry_in`. The bench also sends back-to-back requests, one per cycle, and holds an idle cycle afterward. This checks that a capture and a hold never happen in the same cycle, and that the scoreboard stays in step with `out_valid`.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2
  } fill_e;

endpackage

// File: rtl/opshift_stage.sv
// One power-of-two right-moving stage of the shifter chain.
module opshift_stage
  import opshift_pkg::*;
#(
  parameter int W    = 32,
  parameter int DIST = 1
) (
  input  logic [W-1:0] din,
  input  logic         en,
  input  fill_e        fill,
  output logic [W-1:0] dout
);

  logic [W-1:0] moved;

  always_comb begin
    unique case (fill)
      FILL_SIGN: moved = {{DIST{din[W-1]}}, din[W-1:DIST]};
      FILL_WRAP: moved = {din[DIST-1:0], din[W-1:DIST]};
      default:   moved = {{DIST{1'b0}}, din[W-1:DIST]};
    endcase
    dout = en ? moved : din;
  end

endmodule

// File: rtl/opshift_carry.sv
// Selects the shifter carry-out from the unshifted operand.
module opshift_carry
  import opshift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  op,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] amt,
  input  logic          cin,
  output logic          cout
);

  logic [AW-1:0] idx_right;
  logic [AW-1:0] idx_left;

  always_comb begin
    idx_right = amt - 1'b1;
    idx_left  = ~amt + 1'b1;  // W - amt for power-of-two W
    cout      = cin;
    unique case (kind)
      SK_RRX: cout = op[0];
      SK_LSL: if (amt != '0) cout = op[idx_left];
      SK_LSR,
      SK_ASR,
      SK_ROR: if (amt != '0) cout = op[idx_right];
      default: cout = cin;
    endcase
  end

endmodule

// File: rtl/opshift_unit.sv
module opshift_unit
  import opshift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  operand,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] amount,
  input  logic          carry_in,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          carry_out
);

  localparam int STAGES = AW;

  function automatic logic [W-1:0] bit_reverse(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) bit_reverse[i] = v[W-1-i];
  endfunction

  logic [W-1:0] chain [STAGES+1];
  fill_e        fill_mode;
  logic         is_left;
  logic [W-1:0] shifted;
  logic [W-1:0] next_res;
  logic         next_c;

  always_comb begin
    is_left = (kind == SK_LSL);
    unique case (kind)
      SK_ASR:  fill_mode = FILL_SIGN;
      SK_ROR:  fill_mode = FILL_WRAP;
      default: fill_mode = FILL_ZERO;
    endcase
    chain[0] = is_left ? bit_reverse(operand) : operand;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    opshift_stage #(.W(W), .DIST(1 << s)) u_stage (
      .din  (chain[s]),
      .en   (amount[s]),
      .fill (fill_mode),
      .dout (chain[s+1])
    );
  end

  opshift_carry #(.W(W), .AW(AW)) u_carry (
    .op   (operand),
    .kind (kind),
    .amt  (amount),
    .cin  (carry_in),
    .cout (next_c)
  );

  always_comb begin
    shifted = is_left ? bit_reverse(chain[STAGES]) : chain[STAGES];
    if (kind == SK_RRX)
      next_res = {carry_in, operand[W-1:1]};
    else if (kind > SK_RRX || amount == '0)
      next_res = operand;
    else
      next_res = shifted;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= next_res;
        carry_out <= next_c;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && !$past(rst)) |-> out_valid);  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |-> ($stable(result) && $stable(carry_out)));  // R2
  AST_LSL_ZERO_LSB: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(kind) == SK_LSL && $past(amount) != '0) |-> !result[0]);  // R3
  AST_ASR_SIGN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(kind) == SK_ASR) |-> result[W-1] == $past(operand[W-1]));  // R5
  AST_ROR_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(kind) == SK_ROR) |-> $countones(result) == $countones($past(operand)));  // R6
  AST_ROR_CARRY_MSB: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(kind) == SK_ROR && $past(amount) != '0) |-> carry_out == result[W-1]);  // R6
  AST_RRX_CARRY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(kind) == SK_RRX) |-> (carry_out == $past(operand[0]) && result[W-1] == $past(carry_in)));  // R7
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(kind) < SK_RRX && $past(amount) == '0) |-> (result == $past(operand) && carry_out == $past(carry_in)));  // R8
  AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(kind) > SK_RRX) |-> (result == $past(operand) && carry_out == $past(carry_in)));  // R9

endmodule

// File: tb/opshift_unit_bench.sv
module opshift_unit_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] operand;
  logic [2:0]  kind;
  logic [4:0]  amount;
  logic        carry_in;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] q_res [$];
  logic        q_c   [$];
  string       q_tag [$];
  logic [31:0] last_res;
  logic        last_c;

  always #4 clk = ~clk;

  opshift_unit u_opshift_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
    .kind(kind), .amount(amount), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .carry_out(carry_out)
  );

  // Bit-at-a-time reference built from the requirement text.
  function automatic logic [32:0] model(input logic [31:0] op, input logic [2:0] k,
                                        input logic [4:0] a, input logic ci);
    logic [31:0] v = op;
    logic        c = ci;
    if (k == 3'd4) return {op[0], ci, op[31:1]};
    if (k > 3'd4) return {ci, op};
    for (int i = 0; i < int'(a); i++) begin
      case (k)
        3'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        3'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        3'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual c=%b r=%h expected c=%b r=%h",
               tag, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic send(input logic [31:0] op, input logic [2:0] k, input logic [4:0] a,
                      input logic ci, input string tag);
    logic [32:0] e = model(op, k, a, ci);
    q_res.push_back(e[31:0]);
    q_c.push_back(e[32]);
    q_tag.push_back(tag);
    last_res = e[31:0];
    last_c   = e[32];
    in_valid = 1'b1; operand = op; kind = k; amount = a; carry_in = ci;
    @(negedge clk);
  endtask

  // Monitor: pops one expectation per valid output.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_res.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: unexpected out_valid, actual r=%h expected none", result);
      end else begin
        check(q_tag.pop_front(), {carry_out, result}, {q_c.pop_front(), q_res.pop_front()});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; operand = '0; kind = '0; amount = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", {carry_out, result}, 33'd0);
    check("R1 valid", {32'd0, out_valid}, 33'd0);

    send(32'h8000_0001, 3'd0, 5'd1,  1'b0, "R3 lsl1");
    send(32'h0000_00F0, 3'd0, 5'd28, 1'b0, "R3 lsl28");
    send(32'h8000_0000, 3'd1, 5'd31, 1'b1, "R4 lsr31");
    send(32'h8000_0010, 3'd2, 5'd4,  1'b1, "R5 asr4");
    send(32'h4000_0003, 3'd2, 5'd2,  1'b0, "R5 asr positive");
    send(32'h0000_0001, 3'd3, 5'd1,  1'b0, "R6 ror1");
    send(32'h0000_0003, 3'd4, 5'd7,  1'b1, "R7 rrx nonzero amount");
    send(32'h0000_0002, 3'd4, 5'd0,  1'b1, "R7 rrx zero amount");
    send(32'hDEAD_BEEF, 3'd0, 5'd0,  1'b1, "R8 lsl zero");
    send(32'hDEAD_BEEF, 3'd3, 5'd0,  1'b0, "R8 ror zero");
    send(32'h1234_5678, 3'd5, 5'd3,  1'b1, "R9 code5");
    send(32'h1234_5678, 3'd6, 5'd9,  1'b0, "R9 code6");
    send(32'h8765_4321, 3'd7, 5'd1,  1'b1, "R9 code7");
    for (int n = 0; n < 32; n++) begin
      send(32'hA5C3_1E69, 3'd0, 5'(n), 1'b1, "R3 sweep");
      send(32'hA5C3_1E69, 3'd1, 5'(n), 1'b0, "R4 sweep");
      send(32'hA5C3_1E69, 3'd2, 5'(n), 1'b1, "R5 sweep");
      send(32'h3C96_E10B, 3'd3, 5'(n), 1'b0, "R6 sweep");
    end

    in_valid = 1'b0; operand = 32'hFFFF_FFFF; kind = 3'd1; amount = 5'd5; carry_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 idle valid", {32'd0, out_valid}, 33'd0);
    check("R2 idle hold", {carry_out, result}, {last_c, last_res});
    check("R2 queue drained", {1'b0, 32'(q_res.size())}, 33'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule